// File: doc/BRIEF.md
# Two-way data cache with per-line locking

This block is a 4-Kbyte data cache. It sits between a 32-bit load/store request port and a memory port that can move bursts. It has two ways of 128 sets, and each line holds four 32-bit words. A hit is answered in the cycle that follows its acceptance. A miss takes one of three paths. When the victim line is clean or invalid, the line is filled with a four-beat burst read. When the victim is dirty, it is first written back as a four-beat burst and then the line is filled. When both ways of the set are locked, the access goes straight to memory as a single-word transfer. Each access also carries a write-policy attribute, and this attribute decides whether a write only marks the line dirty (copy-back) or also sends the word to memory (write-through).

Requests come in on a valid/ready handshake. The cache handles one request at a time, so `req_ready` is high only while no request is in progress. A requester that sees `req_ready` low keeps `req_valid` and all request fields steady. Every accepted request gets exactly one `rsp_valid` pulse of one cycle, and the requester must take it; there is no back-pressure on responses. On the memory side the command channel and the write-data channel each use valid/ready, and the cache holds `valid` and the payload steady until `ready` is seen. Read data comes back on `mem_rvalid`, which the cache always accepts.

Top module: `lru_lock_cache`

## Requirements
- R1: After reset every line is invalid and unlocked, `req_ready` is high, and `rsp_valid`, `mem_cmd_valid` and `mem_wvalid` are low.
- R2: A 32-bit address splits into tag bits [31:11], set index bits [10:4], word select bits [3:2] and byte bits [1:0]. A read hit raises `rsp_valid` in the cycle after acceptance, carrying the most recently written value of that word.
- R3: A copy-back write hit (`req_wthru`=0) updates the cached word and marks the line dirty. It creates no memory traffic and responds in the cycle after acceptance.
- R4: A miss with a clean or invalid victim issues one burst read command (`mem_cmd_burst`=1) at the line-aligned address and writes the four returned beats in word order. It responds one clock after the last beat. With zero-wait memory, the response comes 6 cycles after acceptance.
- R5: The victim is chosen in this order: an invalid way, with way 0 tried before way 1; if both ways are valid, the unlocked way; if neither way is locked, the least recently used way. Every hit and every allocation makes the touched way the most recently used.
- R6: A dirty victim is written back as a four-beat burst write at its own line address before the fill command is issued. With zero-wait memory the response comes 11 cycles after acceptance.
- R7: An access with `req_lock`=1 locks the line it hits or allocates. A hit with `req_unlock`=1 and `req_lock`=0 unlocks the line. A locked line is never chosen as a victim.
- R8: When both ways of the set are valid and locked, a miss allocates nothing. A read goes out as a single-word read and returns the memory word 2 cycles after acceptance. A write goes out as a single-word write.
- R9: A write-through write (`req_wthru`=1) updates the cached word, on a hit or after the line is allocated, and leaves the line clean. It then issues a single-word memory write and responds once the data beat has been accepted: 2 cycles after acceptance on a hit, 8 on a miss.
- R10: `req_ready` is low from acceptance until the response cycle. Memory command and write-data signals stay stable while they wait for ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Cache can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wthru | input | 1 | Write policy for this access: 1 = write-through, 0 = copy-back |
| req_lock | input | 1 | Lock the line this access hits or allocates |
| req_unlock | input | 1 | Unlock the line on a hit |
| req_addr | input | 32 | Physical byte address |
| req_wdata | input | 32 | Write word |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Read word, valid with rsp_valid on reads |
| mem_cmd_valid | output | 1 | Memory command present |
| mem_cmd_ready | input | 1 | Memory takes the command |
| mem_cmd_write | output | 1 | 1 = write command |
| mem_cmd_burst | output | 1 | 1 = four-beat line burst, 0 = single word |
| mem_cmd_addr | output | 32 | Byte address of the first beat |
| mem_wvalid | output | 1 | Write beat present |
| mem_wready | input | 1 | Memory takes the write beat |
| mem_wdata | output | 32 | Write beat data |
| mem_rvalid | input | 1 | Read beat present |
| mem_rdata | input | 32 | Read beat data |

## Verification
The hardest case to reach is a set in which both ways are valid and locked. Getting there takes two allocations into one set, each with the lock attribute set, and the next access with a third tag must then bypass the cache. The stimulus builds this state on set 1, then reads and writes a third line twice to show that nothing was allocated, unlocks one way, and repeats the access to show that allocation has resumed. A dirty eviction gets the same treatment: a dirty line is first driven to the least recently used position, and a later re-read proves that its written-back data reached memory.

// File: rtl/lru_lock_cache_pkg.sv
package lru_lock_cache_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_WB_CMD, ST_WB_DAT, ST_FL_CMD, ST_FL_DAT,
    ST_FINISH, ST_SW_CMD, ST_SW_DAT, ST_BY_CMD, ST_BY_RD
  } cache_st_e;

  typedef struct packed {
    logic write;
    logic wthru;
    logic lock;
  } req_attr_t;
endpackage

// File: rtl/cache_meta.sv
module cache_meta #(
  parameter int SETS  = 128,
  parameter int IDX_W = 7,
  parameter int TAG_W = 21
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             hit,
  output logic             hit_way,
  output logic             vic_way,
  output logic             vic_dirty,
  output logic [TAG_W-1:0] vic_tag,
  output logic             all_locked,
  input  logic             upd_en,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic             upd_way,
  input  logic             upd_install,
  input  logic [TAG_W-1:0] upd_tag,
  input  logic             upd_dirty,
  input  logic             upd_lock,
  input  logic             upd_unlock
);
  logic [TAG_W-1:0] tag_q [2][SETS];
  logic             val_q [2][SETS];
  logic             drt_q [2][SETS];
  logic             lck_q [2][SETS];
  logic             lru_q [SETS];   // way index that was used least recently
  logic [1:0]       hv;

  for (genvar w = 0; w < 2; w++) begin : g_match
    assign hv[w] = val_q[w][lk_idx] && (tag_q[w][lk_idx] == lk_tag);
  end

  assign hit        = |hv;
  assign hit_way    = hv[1];
  assign all_locked = val_q[0][lk_idx] && lck_q[0][lk_idx] &&
                      val_q[1][lk_idx] && lck_q[1][lk_idx];

  always_comb begin
    if (!val_q[0][lk_idx])      vic_way = 1'b0;
    else if (!val_q[1][lk_idx]) vic_way = 1'b1;
    else if (lck_q[0][lk_idx])  vic_way = 1'b1;
    else if (lck_q[1][lk_idx])  vic_way = 1'b0;
    else                        vic_way = lru_q[lk_idx];
  end

  assign vic_dirty = val_q[vic_way][lk_idx] && drt_q[vic_way][lk_idx];
  assign vic_tag   = tag_q[vic_way][lk_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        lru_q[s] <= 1'b0;
        for (int w = 0; w < 2; w++) begin
          val_q[w][s] <= 1'b0;
          drt_q[w][s] <= 1'b0;
          lck_q[w][s] <= 1'b0;
        end
      end
    end else if (upd_en) begin
      lru_q[upd_idx] <= !upd_way;
      if (upd_install) val_q[upd_way][upd_idx] <= 1'b1;
      drt_q[upd_way][upd_idx] <= upd_dirty || (!upd_install && drt_q[upd_way][upd_idx]);
      if (upd_lock)                         lck_q[upd_way][upd_idx] <= 1'b1;
      else if (upd_unlock || upd_install)   lck_q[upd_way][upd_idx] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (upd_en && upd_install) tag_q[upd_way][upd_idx] <= upd_tag;
  end

  AST_NO_LOCKED_VICTIM: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en && upd_install |-> !(val_q[upd_way][upd_idx] && lck_q[upd_way][upd_idx])); // R7
endmodule

// File: rtl/cache_data.sv
module cache_data #(
  parameter int SETS   = 128,
  parameter int WORDS  = 4,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 7,
  parameter int WSEL_W = 2
) (
  input  logic              clk,
  input  logic              rd_way,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [WSEL_W-1:0] rd_word,
  output logic [DATA_W-1:0] rd_data,
  input  logic              we,
  input  logic              wr_way,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WSEL_W-1:0] wr_word,
  input  logic [DATA_W-1:0] wr_data
);
  logic [DATA_W-1:0] arr_q [2][SETS][WORDS];

  assign rd_data = arr_q[rd_way][rd_idx][rd_word];

  always_ff @(posedge clk) begin
    if (we) arr_q[wr_way][wr_idx][wr_word] <= wr_data;
  end
endmodule

// File: rtl/lru_lock_cache.sv
module lru_lock_cache
  import lru_lock_cache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int SETS       = 128,
  parameter int LINE_WORDS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_wthru,
  input  logic              req_lock,
  input  logic              req_unlock,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_cmd_valid,
  input  logic              mem_cmd_ready,
  output logic              mem_cmd_write,
  output logic              mem_cmd_burst,
  output logic [ADDR_W-1:0] mem_cmd_addr,
  output logic              mem_wvalid,
  input  logic              mem_wready,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int BYTE_OFF = $clog2(DATA_W / 8);
  localparam int WSEL_W   = $clog2(LINE_WORDS);
  localparam int OFF_W    = BYTE_OFF + WSEL_W;
  localparam int IDX_W    = $clog2(SETS);
  localparam int TAG_W    = ADDR_W - IDX_W - OFF_W;
  localparam logic [WSEL_W-1:0] LAST_BEAT = WSEL_W'(LINE_WORDS - 1);

  cache_st_e         st;
  logic [ADDR_W-1:0] lat_addr, lk_addr;
  logic [DATA_W-1:0] lat_wdata, rd_data, wr_data;
  req_attr_t         lat_at;
  logic              lat_way;
  logic [TAG_W-1:0]  lat_vtag, lk_tag, vic_tag;
  logic [IDX_W-1:0]  lk_idx;
  logic [WSEL_W-1:0] lk_word, beat, rd_word, wr_word;
  logic              idle, accept, hit, hit_way, vic_way, vic_dirty, all_locked;
  logic              upd_en, upd_way, upd_install, upd_dirty, upd_lock, upd_unlock;
  logic              we, wr_way, rd_way;

  assign idle      = (st == ST_IDLE);
  assign req_ready = idle;
  assign accept    = req_valid && idle;
  assign lk_addr   = idle ? req_addr : lat_addr;
  assign lk_idx    = lk_addr[OFF_W +: IDX_W];
  assign lk_tag    = lk_addr[ADDR_W-1 -: TAG_W];
  assign lk_word   = lk_addr[BYTE_OFF +: WSEL_W];

  cache_meta #(.SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_meta (
    .clk, .rst_n, .lk_idx, .lk_tag, .hit, .hit_way, .vic_way, .vic_dirty,
    .vic_tag, .all_locked, .upd_en, .upd_idx(lk_idx), .upd_way, .upd_install,
    .upd_tag(lk_tag), .upd_dirty, .upd_lock, .upd_unlock);

  always_comb begin
    upd_en = 1'b0; upd_way = lat_way; upd_install = 1'b0;
    upd_dirty = 1'b0; upd_lock = 1'b0; upd_unlock = 1'b0;
    if (accept && hit) begin
      upd_en = 1'b1; upd_way = hit_way;
      upd_dirty  = req_write && !req_wthru;
      upd_lock   = req_lock;
      upd_unlock = req_unlock;
    end else if (st == ST_FINISH) begin
      upd_en = 1'b1; upd_install = 1'b1;
      upd_dirty = lat_at.write && !lat_at.wthru;
      upd_lock  = lat_at.lock;
    end
  end

  assign rd_way  = idle ? hit_way : lat_way;
  assign rd_word = (st == ST_WB_DAT) ? beat : lk_word;

  always_comb begin
    we = 1'b0; wr_way = lat_way; wr_word = lk_word; wr_data = lat_wdata;
    if (accept && hit && req_write) begin
      we = 1'b1; wr_way = hit_way; wr_data = req_wdata;
    end else if (st == ST_FL_DAT && mem_rvalid) begin
      we = 1'b1; wr_word = beat; wr_data = mem_rdata;
    end else if (st == ST_FINISH && lat_at.write) begin
      we = 1'b1;
    end
  end

  cache_data #(.SETS(SETS), .WORDS(LINE_WORDS), .DATA_W(DATA_W), .IDX_W(IDX_W),
               .WSEL_W(WSEL_W)) u_data (
    .clk, .rd_way, .rd_idx(lk_idx), .rd_word, .rd_data,
    .we, .wr_way, .wr_idx(lk_idx), .wr_word, .wr_data);

  assign mem_cmd_valid = st inside {ST_WB_CMD, ST_FL_CMD, ST_SW_CMD, ST_BY_CMD};
  assign mem_cmd_write = st inside {ST_WB_CMD, ST_SW_CMD};
  assign mem_cmd_burst = st inside {ST_WB_CMD, ST_FL_CMD};
  assign mem_wvalid    = st inside {ST_WB_DAT, ST_SW_DAT};
  assign mem_wdata     = (st == ST_WB_DAT) ? rd_data : lat_wdata;

  always_comb begin
    if (st == ST_WB_CMD)      mem_cmd_addr = {lat_vtag, lk_idx, {OFF_W{1'b0}}};
    else if (st == ST_FL_CMD) mem_cmd_addr = {lk_tag, lk_idx, {OFF_W{1'b0}}};
    else                      mem_cmd_addr = {lat_addr[ADDR_W-1:BYTE_OFF], {BYTE_OFF{1'b0}}};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE; rsp_valid <= 1'b0; rsp_rdata <= '0; beat <= '0;
      lat_addr <= '0; lat_wdata <= '0; lat_at <= '0; lat_way <= 1'b0; lat_vtag <= '0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (st)
        ST_IDLE: if (accept) begin
          lat_addr <= req_addr; lat_wdata <= req_wdata;
          lat_at   <= '{write: req_write, wthru: req_wthru, lock: req_lock};
          lat_way  <= vic_way; lat_vtag <= vic_tag; beat <= '0;
          if (hit) begin
            if (req_write && req_wthru) st <= ST_SW_CMD;
            else begin rsp_valid <= 1'b1; rsp_rdata <= rd_data; end
          end else if (all_locked) st <= req_write ? ST_SW_CMD : ST_BY_CMD;
          else st <= vic_dirty ? ST_WB_CMD : ST_FL_CMD;
        end
        ST_WB_CMD: if (mem_cmd_ready) st <= ST_WB_DAT;
        ST_WB_DAT: if (mem_wready) begin
          beat <= beat + 1'b1;
          if (beat == LAST_BEAT) st <= ST_FL_CMD;
        end
        ST_FL_CMD: if (mem_cmd_ready) st <= ST_FL_DAT;
        ST_FL_DAT: if (mem_rvalid) begin
          beat <= beat + 1'b1;
          if (beat == LAST_BEAT) st <= ST_FINISH;
        end
        ST_FINISH: begin
          if (lat_at.write && lat_at.wthru) st <= ST_SW_CMD;
          else begin st <= ST_IDLE; rsp_valid <= 1'b1; rsp_rdata <= rd_data; end
        end
        ST_SW_CMD: if (mem_cmd_ready) st <= ST_SW_DAT;
        ST_SW_DAT: if (mem_wready) begin st <= ST_IDLE; rsp_valid <= 1'b1; end
        ST_BY_CMD: if (mem_cmd_ready) st <= ST_BY_RD;
        ST_BY_RD: if (mem_rvalid) begin
          st <= ST_IDLE; rsp_valid <= 1'b1; rsp_rdata <= mem_rdata;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_HIT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    accept && hit && !(req_write && req_wthru) |=> rsp_valid); // R2
  AST_COPYBACK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    accept && hit && req_write && !req_wthru |=> !mem_cmd_valid && !mem_wvalid); // R3
  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cmd_valid && !mem_cmd_ready |=> mem_cmd_valid && $stable(mem_cmd_addr)); // R10
  AST_WDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wvalid && !mem_wready |=> mem_wvalid && $stable(mem_wdata)); // R6
  AST_BUSY_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cmd_valid || mem_wvalid |-> !req_ready); // R10
endmodule

// File: tb/test_lru_lock_cache.sv
module test_lru_lock_cache;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_wthru = 1'b0, req_lock = 1'b0, req_unlock = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic req_ready, rsp_valid, mem_cmd_valid, mem_cmd_write, mem_cmd_burst, mem_wvalid;
  logic [31:0] rsp_rdata, mem_cmd_addr, mem_wdata;
  logic mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;

  int total = 0, bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  lru_lock_cache i_lru_lock_cache (
    .clk, .rst_n, .req_valid, .req_ready, .req_write, .req_wthru, .req_lock,
    .req_unlock, .req_addr, .req_wdata, .rsp_valid, .rsp_rdata, .mem_cmd_valid,
    .mem_cmd_ready(1'b1), .mem_cmd_write, .mem_cmd_burst, .mem_cmd_addr,
    .mem_wvalid, .mem_wready(1'b1), .mem_wdata, .mem_rvalid, .mem_rdata);

  // memory slave: zero-wait, read beats start the cycle after command acceptance
  logic [31:0] bmem [int];
  int rd_left = 0;
  logic [31:0] rd_ptr = '0, wr_ptr = '0;

  function automatic logic [31:0] dflt(input logic [31:0] a);
    return a ^ 32'hC0DE_0000;
  endfunction

  function automatic logic [31:0] bread(input logic [31:0] a);
    return bmem.exists(int'(a)) ? bmem[int'(a)] : dflt(a);
  endfunction

  always @(negedge clk) begin
    if (rd_left > 0) begin
      mem_rvalid = 1'b1; mem_rdata = bread(rd_ptr);
      rd_ptr += 4; rd_left--;
    end else mem_rvalid = 1'b0;
    if (mem_cmd_valid) begin
      if (mem_cmd_write) wr_ptr = mem_cmd_addr;
      else begin rd_ptr = mem_cmd_addr; rd_left = mem_cmd_burst ? 4 : 1; end
    end
    if (mem_wvalid) begin bmem[int'(wr_ptr)] = mem_wdata; wr_ptr += 4; end
  end

  // behavioural reference model
  logic [20:0] m_tag [2][128];
  bit m_val [2][128], m_drt [2][128], m_lck [2][128];
  bit m_lru [128];
  logic [31:0] shadow [int];

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  function automatic logic [31:0] adr(input int tg, input int idx, input int wd);
    return {tg[20:0], idx[6:0], wd[1:0], 2'b00};
  endfunction

  task automatic access(input string rq, input bit wr, input bit wt, input bit lk,
                        input bit ul, input logic [31:0] a, input logic [31:0] wd);
    int idx, hw, v, lat;
    logic [20:0] tg;
    logic [31:0] exp_d;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_wthru = wt; req_lock = lk;
    req_unlock = ul; req_addr = a; req_wdata = wd;
    idx = int'(a[10:4]); tg = a[31:11]; hw = -1;
    for (int w = 0; w < 2; w++) if (m_val[w][idx] && m_tag[w][idx] == tg) hw = w;
    if (hw >= 0) begin
      lat = (wr && wt) ? 2 : 0;
      if (wr && !wt) m_drt[hw][idx] = 1;
      if (lk) m_lck[hw][idx] = 1; else if (ul) m_lck[hw][idx] = 0;
      m_lru[idx] = (hw == 0);
    end else if (m_val[0][idx] && m_lck[0][idx] && m_val[1][idx] && m_lck[1][idx]) begin
      lat = 2;
    end else begin
      if (!m_val[0][idx]) v = 0;
      else if (!m_val[1][idx]) v = 1;
      else if (m_lck[0][idx]) v = 1;
      else if (m_lck[1][idx]) v = 0;
      else v = int'(m_lru[idx]);
      lat = 6 + ((m_val[v][idx] && m_drt[v][idx]) ? 5 : 0) + ((wr && wt) ? 2 : 0);
      m_val[v][idx] = 1; m_tag[v][idx] = tg; m_drt[v][idx] = wr && !wt;
      m_lck[v][idx] = lk; m_lru[idx] = (v == 0);
    end
    if (wr) shadow[int'(a)] = wd;
    exp_d = shadow.exists(int'(a)) ? shadow[int'(a)] : dflt(a);
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i <= lat; i++) begin
      if (i > 0) @(negedge clk);
      chk(rsp_valid == (i == lat), rq, $sformatf("rsp_valid cycle %0d", i),
          32'(rsp_valid), 32'(i == lat));
      chk(req_ready == (i == lat), "R10", $sformatf("req_ready cycle %0d", i),
          32'(req_ready), 32'(i == lat));
    end
    if (!wr) chk(rsp_rdata == exp_d, rq, "read data", rsp_rdata, exp_d);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "req_ready after reset", 32'(req_ready), 1);
    chk(rsp_valid == 1'b0, "R1", "rsp_valid after reset", 32'(rsp_valid), 0);
    chk(mem_cmd_valid == 1'b0 && mem_wvalid == 1'b0, "R1", "memory idle after reset",
        32'({mem_cmd_valid, mem_wvalid}), 0);
    // set 0: fills, hits, copy-back write, LRU eviction with write-back
    access("R4", 0, 0, 0, 0, adr(1, 0, 0), 0);
    access("R2", 0, 0, 0, 0, adr(1, 0, 0), 0);
    access("R2", 0, 0, 0, 0, adr(1, 0, 3), 0);
    access("R3", 1, 0, 0, 0, adr(1, 0, 2), 32'hDEAD_0001);
    access("R3", 0, 0, 0, 0, adr(1, 0, 2), 0);
    access("R4", 0, 0, 0, 0, adr(2, 0, 1), 0);
    access("R2", 0, 0, 0, 0, adr(1, 0, 2), 0);
    access("R5", 0, 0, 0, 0, adr(3, 0, 0), 0);
    access("R6", 1, 0, 0, 0, adr(3, 0, 1), 32'h1234_5678);
    access("R5", 0, 0, 0, 0, adr(1, 0, 2), 0);
    access("R6", 0, 0, 0, 0, adr(2, 0, 0), 0);
    access("R6", 0, 0, 0, 0, adr(3, 0, 1), 0);
    // set 1: locking and bypass
    access("R7", 0, 0, 1, 0, adr(4, 1, 0), 0);
    access("R4", 0, 0, 0, 0, adr(5, 1, 0), 0);
    access("R2", 0, 0, 0, 0, adr(5, 1, 1), 0);
    access("R7", 0, 0, 0, 0, adr(6, 1, 0), 0);
    access("R7", 0, 0, 0, 0, adr(4, 1, 2), 0);
    access("R7", 0, 0, 1, 0, adr(6, 1, 3), 0);
    access("R8", 0, 0, 0, 0, adr(7, 1, 0), 0);
    access("R8", 0, 0, 0, 0, adr(7, 1, 0), 0);
    access("R8", 1, 0, 0, 0, adr(7, 1, 1), 32'hB0B0_0007);
    access("R8", 0, 0, 0, 0, adr(7, 1, 1), 0);
    access("R7", 0, 0, 0, 1, adr(4, 1, 0), 0);
    access("R7", 0, 0, 0, 0, adr(6, 1, 0), 0);
    access("R7", 0, 0, 0, 0, adr(7, 1, 1), 0);
    access("R7", 0, 0, 0, 0, adr(6, 1, 3), 0);
    // set 2: write-through hit and miss, clean eviction
    access("R4", 0, 0, 0, 0, adr(8, 2, 0), 0);
    access("R9", 1, 1, 0, 0, adr(8, 2, 2), 32'hFACE_0002);
    access("R9", 0, 0, 0, 0, adr(8, 2, 2), 0);
    access("R9", 1, 1, 0, 0, adr(9, 2, 1), 32'hFACE_0003);
    access("R9", 0, 0, 0, 0, adr(10, 2, 0), 0);
    access("R9", 0, 0, 0, 0, adr(11, 2, 0), 0);
    access("R9", 0, 0, 0, 0, adr(8, 2, 2), 0);
    access("R9", 0, 0, 0, 0, adr(9, 2, 1), 0);
    // copy-back write miss, then dirty eviction of it
    access("R3", 1, 0, 0, 0, adr(12, 3, 3), 32'h0DD0_0004);
    access("R4", 0, 0, 0, 0, adr(13, 3, 0), 0);
    access("R6", 0, 0, 0, 0, adr(14, 3, 0), 0);
    access("R6", 0, 0, 0, 0, adr(12, 3, 3), 0);
    repeat (2) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule